// File: doc/BRIEF.md
# Float-to-Integer Converter with Selectable Invalid-Result Policy

This block turns one IEEE 754 operand, single or double precision, into a signed 32-bit or 64-bit integer. Each request carries an operation code that fixes how the fraction is discarded. The plain convert operation follows the rounding mode currently programmed in the FP control register. The other four operations each force one rounding direction for that request only.

A per-request policy bit decides what comes back when the conversion is invalid. In saturating (2008-style) mode, a NaN yields zero and an out-of-range value clamps to the integer limit of its sign. In legacy mode the result is always the largest positive integer of the destination width. Alongside the integer, the block reports invalid, overflow and inexact flags. A request is accepted whenever `req_valid` is high, with no back-pressure. Its result and flags appear one clock later, qualified by `rsp_valid`.

Top module: `fcvt_top`

## Requirements
- R1: A request sampled with `req_valid` high produces `rsp_valid` high on the next clock; a cycle without a request produces `rsp_valid` low on the next clock. A synchronous active-high `rst` clears `rsp_valid`, `rsp_result` and all three flags.
- R2: Four combinations are supported. `req_is_double` = 1 takes all 64 operand bits as double precision; 0 takes `req_operand[31:0]` as single precision. `req_to_long` = 1 gives a 64-bit result; 0 gives a 32-bit result in `rsp_result[31:0]`, with bits 63:32 zero.
- R3: `req_op` = 0 (convert) rounds with `req_rmode`, encoded as 0 nearest-even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity. Codes 5 to 7 act as convert.
- R4: `req_op` = 1 always rounds to nearest-even, 2 always toward zero, 3 always toward plus infinity and 4 always toward minus infinity, whatever `req_rmode` holds.
- R5: A forced rounding direction affects only its own request. A convert request issued in the next cycle uses `req_rmode` again.
- R6: With `req_ieee_sat` = 1, any NaN input (quiet or signalling) gives result zero.
- R7: With `req_ieee_sat` = 1, an infinity or a finite value out of range after rounding gives the most negative integer of the destination width for a negative sign. For a positive sign it gives the most positive integer.
- R8: With `req_ieee_sat` = 0, every invalid conversion gives 0x7FFFFFFF (32-bit) or 0x7FFFFFFFFFFFFFFF (64-bit), whatever the sign or NaN status.
- R9: `rsp_inexact` is 1 exactly when discarded fraction bits are non-zero and the conversion is not invalid.
- R10: Zero converts exactly to 0. A subnormal input converts to 0, +1 or -1 as the rounding direction dictates, and raises inexact.
- R11: The range test is applied after rounding. The most negative integer of each width converts exactly. A value that rounds up to 2^31 (32-bit) or reaches 2^63 (64-bit) is out of range.
- R12: A NaN raises invalid and not overflow. An infinity or an out-of-range finite value raises both invalid and overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request qualifier |
| req_operand | input | 64 | Floating-point operand (single in bits 31:0) |
| req_is_double | input | 1 | 1 = double precision source, 0 = single |
| req_to_long | input | 1 | 1 = 64-bit destination, 0 = 32-bit |
| req_op | input | 3 | 0 convert, 1 round, 2 truncate, 3 ceiling, 4 floor |
| req_ieee_sat | input | 1 | 1 = saturating policy, 0 = legacy policy |
| req_rmode | input | 2 | Rounding mode from the FP control register |
| rsp_valid | output | 1 | Result qualifier, one cycle after the request |
| rsp_result | output | 64 | Converted integer |
| rsp_invalid | output | 1 | Invalid-operation flag |
| rsp_overflow | output | 1 | Overflow flag |
| rsp_inexact | output | 1 | Inexact flag |

## Verification
Some properties are checked on every cycle: the one-cycle valid handshake, zero upper bits for 32-bit destinations, the NaN results under both policies, infinity raising both flags, and that inexact never accompanies invalid and overflow never appears without invalid. Other behaviour is shown only by the bench scenarios, which compare each response with a behavioural model. These cover the correct rounding direction for each operation and mode, the one-request scope of a forced direction, the tie and exact-boundary cases around 2^31 and 2^63, and subnormal and signed-zero results.

// File: rtl/fcvt_pkg.sv
package fcvt_pkg;
    localparam int OPND_W     = 64;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;
    localparam int DBL_BIAS   = 1023;
    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int SGL_BIAS   = 127;
    localparam int INT_W      = 64;
    localparam int NARROW_W   = 32;
    localparam int SIG_W      = DBL_FRAC_W + 1;
    localparam int EXP_W      = DBL_EXP_W + 2;
    localparam int SHIFT_W    = $clog2(INT_W);
    localparam int WIDE_W     = SIG_W + INT_W;
    localparam int MAG_W      = INT_W + 1;

    typedef enum logic [2:0] {
        OP_CVT  = 3'd0,
        OP_RND  = 3'd1,
        OP_TRN  = 3'd2,
        OP_CEIL = 3'd3,
        OP_FLR  = 3'd4
    } conv_op_e;

    typedef enum logic [1:0] {
        RM_NEAR = 2'd0,
        RM_ZERO = 2'd1,
        RM_POS  = 2'd2,
        RM_NEG  = 2'd3
    } rmode_e;

    // decoded operand, common to both source formats
    typedef struct packed {
        logic             sign;
        logic             is_nan;
        logic             is_inf;
        logic             is_zero;
        logic             is_sub;
        logic [EXP_W-1:0] exp;   // unbiased, two's complement
        logic [SIG_W-1:0] sig;   // hidden bit at the top
    } unpacked_t;

    // integer magnitude before rounding, with guard information
    typedef struct packed {
        logic [MAG_W-1:0] mag;
        logic             rnd;
        logic             stk;
        logic             big;
    } magn_t;

    function automatic rmode_e effective_mode(conv_op_e op, rmode_e cur);
        case (op)
            OP_RND:  return RM_NEAR;
            OP_TRN:  return RM_ZERO;
            OP_CEIL: return RM_POS;
            OP_FLR:  return RM_NEG;
            default: return cur;
        endcase
    endfunction

    function automatic logic need_increment(rmode_e m, logic sign, logic lsb,
                                            logic rnd, logic stk);
        case (m)
            RM_NEAR: return rnd & (stk | lsb);
            RM_ZERO: return 1'b0;
            RM_POS:  return (rnd | stk) & ~sign;
            default: return (rnd | stk) & sign;
        endcase
    endfunction
endpackage

// File: rtl/fcvt_unpack.sv
module fcvt_unpack
    import fcvt_pkg::*;
(
    input  logic [OPND_W-1:0] opnd,
    input  logic              is_double,
    output unpacked_t         up
);
    // one decoder per source format, selected by is_double
    for (genvar g = 0; g < 2; g++) begin : g_fmt
        localparam int EW   = (g == 1) ? DBL_EXP_W  : SGL_EXP_W;
        localparam int FW   = (g == 1) ? DBL_FRAC_W : SGL_FRAC_W;
        localparam int BIAS = (g == 1) ? DBL_BIAS   : SGL_BIAS;
        localparam int TOP  = EW + FW;

        logic [EW-1:0] ef;
        logic [FW-1:0] ff;
        unpacked_t     dec;

        assign ef = opnd[TOP-1 -: EW];
        assign ff = opnd[FW-1:0];

        always_comb begin
            dec.sign    = opnd[TOP];
            dec.is_nan  = (&ef) & (|ff);
            dec.is_inf  = (&ef) & ~(|ff);
            dec.is_zero = ~(|ef) & ~(|ff);
            dec.is_sub  = ~(|ef) & (|ff);
            dec.exp     = EXP_W'(ef) - EXP_W'(BIAS);
            dec.sig     = SIG_W'({1'b1, ff}) << (SIG_W - 1 - FW);
        end
    end

    assign up = is_double ? g_fmt[1].dec : g_fmt[0].dec;
endmodule

// File: rtl/fcvt_align.sv
module fcvt_align
    import fcvt_pkg::*;
(
    input  logic [EXP_W-1:0] exp,
    input  logic [SIG_W-1:0] sig,
    input  logic             is_zero,
    input  logic             is_sub,
    output magn_t            mg
);
    logic signed [EXP_W-1:0] e_s;
    logic [WIDE_W-1:0]       wide;

    assign e_s  = $signed(exp);
    // fixed point: integer part above bit SIG_W-1
    assign wide = {{INT_W{1'b0}}, sig} << exp[SHIFT_W-1:0];

    always_comb begin
        mg = '0;
        if (is_zero) begin
            mg.big = 1'b0;
        end else if (is_sub) begin
            mg.stk = 1'b1;
        end else if (e_s >= $signed(EXP_W'(INT_W))) begin
            mg.big = 1'b1;
        end else if (e_s >= 0) begin
            mg.mag = wide[WIDE_W-1 -: MAG_W];
            mg.rnd = wide[SIG_W-2];
            mg.stk = |wide[SIG_W-3:0];
        end else if (e_s == -1) begin
            mg.rnd = 1'b1;
            mg.stk = |sig[SIG_W-2:0];
        end else begin
            mg.stk = 1'b1;
        end
    end
endmodule

// File: rtl/fcvt_round_sat.sv
module fcvt_round_sat
    import fcvt_pkg::*;
(
    input  magn_t             mg,
    input  logic              sign,
    input  logic              is_nan,
    input  logic              is_inf,
    input  rmode_e            mode,
    input  logic              to_long,
    input  logic              ieee_sat,
    output logic [INT_W-1:0]  result,
    output logic              invalid,
    output logic              overflow,
    output logic              inexact
);
    logic             inc;
    logic [MAG_W-1:0] mag_r;
    logic [MAG_W-1:0] limit;
    logic             oor;
    logic             exc;
    logic [INT_W-1:0] signed_val;
    logic [INT_W-1:0] pos_max;
    logic [INT_W-1:0] neg_min;

    assign inc   = need_increment(mode, sign, mg.mag[0], mg.rnd, mg.stk);
    assign mag_r = mg.mag + MAG_W'(inc);
    assign limit = to_long ? (MAG_W'(1) << (INT_W - 1)) : (MAG_W'(1) << (NARROW_W - 1));
    // negative side may reach the limit itself, positive side may not
    assign oor   = mg.big | (sign ? (mag_r > limit) : (mag_r >= limit));
    assign exc   = is_nan | is_inf | oor;

    assign pos_max = to_long ? {1'b0, {(INT_W-1){1'b1}}}
                             : INT_W'({1'b0, {(NARROW_W-1){1'b1}}});
    assign neg_min = to_long ? {1'b1, {(INT_W-1){1'b0}}}
                             : INT_W'({1'b1, {(NARROW_W-1){1'b0}}});

    assign signed_val = sign ? (~mag_r[INT_W-1:0] + 1'b1) : mag_r[INT_W-1:0];

    always_comb begin
        invalid  = exc;
        overflow = exc & ~is_nan;
        inexact  = ~exc & (mg.rnd | mg.stk);
        if (exc) begin
            if (ieee_sat) begin
                result = is_nan ? '0 : (sign ? neg_min : pos_max);
            end else begin
                result = pos_max;
            end
        end else if (to_long) begin
            result = signed_val;
        end else begin
            result = {{(INT_W-NARROW_W){1'b0}}, signed_val[NARROW_W-1:0]};
        end
    end
endmodule

// File: rtl/fcvt_top.sv
module fcvt_top
    import fcvt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [OPND_W-1:0] req_operand,
    input  logic              req_is_double,
    input  logic              req_to_long,
    input  logic [2:0]        req_op,
    input  logic              req_ieee_sat,
    input  logic [1:0]        req_rmode,
    output logic              rsp_valid,
    output logic [INT_W-1:0]  rsp_result,
    output logic              rsp_invalid,
    output logic              rsp_overflow,
    output logic              rsp_inexact
);
    unpacked_t        up;
    magn_t            mg;
    rmode_e           mode;
    logic [INT_W-1:0] c_result;
    logic             c_invalid;
    logic             c_overflow;
    logic             c_inexact;

    assign mode = effective_mode(conv_op_e'(req_op), rmode_e'(req_rmode));

    fcvt_unpack u_unpack (
        .opnd      (req_operand),
        .is_double (req_is_double),
        .up        (up)
    );

    fcvt_align u_align (
        .exp     (up.exp),
        .sig     (up.sig),
        .is_zero (up.is_zero),
        .is_sub  (up.is_sub),
        .mg      (mg)
    );

    fcvt_round_sat u_round (
        .mg       (mg),
        .sign     (up.sign),
        .is_nan   (up.is_nan),
        .is_inf   (up.is_inf),
        .mode     (mode),
        .to_long  (req_to_long),
        .ieee_sat (req_ieee_sat),
        .result   (c_result),
        .invalid  (c_invalid),
        .overflow (c_overflow),
        .inexact  (c_inexact)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid    <= 1'b0;
            rsp_result   <= '0;
            rsp_invalid  <= 1'b0;
            rsp_overflow <= 1'b0;
            rsp_inexact  <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_result   <= c_result;
                rsp_invalid  <= c_invalid;
                rsp_overflow <= c_overflow;
                rsp_inexact  <= c_inexact;
            end
        end
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R1
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R1
    AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_to_long) |=> (rsp_result[INT_W-1:NARROW_W] == '0)); // R2
    AST_SAT_NAN_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ieee_sat && up.is_nan) |=> (rsp_result == '0 && rsp_invalid)); // R6
    AST_LEGACY_FIXED: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ieee_sat && up.is_nan) |=>
        (rsp_result == ($past(req_to_long) ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF))); // R8
    AST_INEXACT_EXCL: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !(rsp_invalid && rsp_inexact)); // R9
    AST_OVF_NEEDS_INV: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_overflow) |-> rsp_invalid); // R12
    AST_INF_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (req_valid && up.is_inf) |=> (rsp_overflow && rsp_invalid)); // R12
    AST_NAN_NO_OVF: assert property (@(posedge clk) disable iff (rst)
        (req_valid && up.is_nan) |=> (rsp_invalid && !rsp_overflow)); // R12
endmodule

// File: tb/fcvt_top_tb_top.sv
`timescale 1ns/1ps
module fcvt_top_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [63:0] req_operand = '0;
    logic        req_is_double = 1'b0;
    logic        req_to_long = 1'b0;
    logic [2:0]  req_op = '0;
    logic        req_ieee_sat = 1'b0;
    logic [1:0]  req_rmode = '0;
    logic        rsp_valid;
    logic [63:0] rsp_result;
    logic        rsp_invalid, rsp_overflow, rsp_inexact;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic        exp_v = 1'b0;
    logic [63:0] exp_res;
    logic        exp_inv, exp_ovf, exp_inx;
    string       exp_tag = "R1";

    always #2 clk = ~clk;

    fcvt_top dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_operand(req_operand),
        .req_is_double(req_is_double), .req_to_long(req_to_long), .req_op(req_op),
        .req_ieee_sat(req_ieee_sat), .req_rmode(req_rmode), .rsp_valid(rsp_valid),
        .rsp_result(rsp_result), .rsp_invalid(rsp_invalid),
        .rsp_overflow(rsp_overflow), .rsp_inexact(rsp_inexact)
    );

    // behavioural reference built from the requirements
    function automatic void ref_conv(input logic [63:0] opnd, input logic dbl, input logic lng,
                                     input logic [2:0] op, input logic sat, input logic [1:0] rm,
                                     output logic [63:0] res, output logic inv,
                                     output logic ovf, output logic inx);
        logic sgn, nan_i, inf_i, big, inc, oor;
        int expf, emax, bias, e, cls, mode;
        logic [51:0]  frac;
        logic [127:0] mnt, ip, rem, half, mag, lim;
        logic [63:0]  sv;
        if (dbl) begin
            sgn = opnd[63]; expf = int'(opnd[62:52]); frac = opnd[51:0];
            emax = 2047; bias = 1023;
        end else begin
            sgn = opnd[31]; expf = int'(opnd[30:23]); frac = {opnd[22:0], 29'd0};
            emax = 255; bias = 127;
        end
        nan_i = (expf == emax) && (frac != 0);
        inf_i = (expf == emax) && (frac == 0);
        case (op)
            3'd1: mode = 0;
            3'd2: mode = 1;
            3'd3: mode = 2;
            3'd4: mode = 3;
            default: mode = int'(rm);
        endcase
        ip = '0; cls = 0; big = 1'b0; rem = '0; half = '0;
        if (expf == emax) big = 1'b1;
        else if (expf == 0) cls = (frac == 0) ? 0 : 1;
        else begin
            e = expf - bias;
            mnt = {75'd0, 1'b1, frac};
            if (e >= 64) big = 1'b1;
            else if (e >= 52) ip = mnt << (e - 52);
            else if (e >= 0) begin
                ip = mnt >> (52 - e);
                rem = mnt - (ip << (52 - e));
                half = 128'd1 << (51 - e);
                if (rem == 0) cls = 0;
                else if (rem < half) cls = 1;
                else if (rem == half) cls = 2;
                else cls = 3;
            end else if (e == -1) cls = (frac == 0) ? 2 : 3;
            else cls = 1;
        end
        case (mode)
            0: inc = (cls == 3) || (cls == 2 && ip[0]);
            1: inc = 1'b0;
            2: inc = (cls != 0) && !sgn;
            default: inc = (cls != 0) && sgn;
        endcase
        mag = ip + {127'd0, inc};
        lim = lng ? (128'd1 << 63) : (128'd1 << 31);
        oor = big || (sgn ? (mag > lim) : (mag >= lim));
        inv = nan_i || inf_i || oor;
        ovf = inv && !nan_i;
        inx = !inv && (cls != 0);
        if (inv) begin
            if (sat && nan_i) res = '0;
            else if (sat && sgn) res = lng ? 64'h8000_0000_0000_0000 : 64'h0000_0000_8000_0000;
            else res = lng ? 64'h7FFF_FFFF_FFFF_FFFF : 64'h0000_0000_7FFF_FFFF;
        end else begin
            sv = sgn ? (64'd0 - mag[63:0]) : mag[63:0];
            res = lng ? sv : {32'd0, sv[31:0]};
        end
    endfunction

    task automatic compare();
        checks++;
        if (exp_v) begin
            if (rsp_valid !== 1'b1 || rsp_result !== exp_res || rsp_invalid !== exp_inv ||
                rsp_overflow !== exp_ovf || rsp_inexact !== exp_inx) begin
                failures++;
                $display("FAIL %s actual v=%b res=%h inv=%b ovf=%b inx=%b expected v=1 res=%h inv=%b ovf=%b inx=%b",
                         exp_tag, rsp_valid, rsp_result, rsp_invalid, rsp_overflow, rsp_inexact,
                         exp_res, exp_inv, exp_ovf, exp_inx);
            end
        end else if (rsp_valid !== 1'b0) begin
            failures++;
            $display("FAIL R1 idle actual rsp_valid=%b expected 0", rsp_valid);
        end
    endtask

    task automatic drive(input string tag, input logic [63:0] opnd, input logic dbl,
                         input logic lng, input logic [2:0] op, input logic sat,
                         input logic [1:0] rm);
        logic [63:0] r;
        logic a, b, c;
        @(negedge clk);
        compare();
        req_valid = 1'b1; req_operand = opnd; req_is_double = dbl; req_to_long = lng;
        req_op = op; req_ieee_sat = sat; req_rmode = rm;
        ref_conv(opnd, dbl, lng, op, sat, rm, r, a, b, c);
        exp_v = 1'b1; exp_res = r; exp_inv = a; exp_ovf = b; exp_inx = c; exp_tag = tag;
    endtask

    task automatic idle();
        @(negedge clk);
        compare();
        req_valid = 1'b0;
        exp_v = 1'b0; exp_tag = "R1";
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        checks++;
        if (rsp_valid !== 1'b0 || rsp_result !== 64'd0 || rsp_invalid !== 1'b0 ||
            rsp_overflow !== 1'b0 || rsp_inexact !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual v=%b res=%h expected v=0 res=0", rsp_valid, rsp_result);
        end
        idle();
        // R2 format combinations
        drive("R2 s->w", 64'h0000_0000_4040_0000, 0, 0, 3'd0, 1, 2'd0);
        drive("R2 d->w", 64'h4008_0000_0000_0000, 1, 0, 3'd0, 1, 2'd0);
        drive("R2 s->l", 64'h0000_0000_C0A0_0000, 0, 1, 3'd0, 1, 2'd0);
        drive("R2 d->w neg", 64'hC0A0_0000_0000_0000, 1, 0, 3'd0, 0, 2'd0);
        // R3 convert follows rmode, R9 inexact
        drive("R3 R9 near", 64'h4004_0000_0000_0000, 1, 1, 3'd0, 1, 2'd0);
        drive("R3 zero",    64'h4004_0000_0000_0000, 1, 1, 3'd0, 1, 2'd1);
        drive("R3 pos",     64'h4004_0000_0000_0000, 1, 1, 3'd0, 1, 2'd2);
        drive("R3 neg",     64'hC004_0000_0000_0000, 1, 1, 3'd0, 1, 2'd3);
        drive("R3 code7",   64'hC004_0000_0000_0000, 1, 0, 3'd7, 1, 2'd2);
        // R4 forced directions ignore rmode
        drive("R4 round",   64'h400C_0000_0000_0000, 1, 0, 3'd1, 1, 2'd1);
        drive("R4 round tie even", 64'h4004_0000_0000_0000, 1, 0, 3'd1, 1, 2'd2);
        drive("R4 trunc",   64'hC00C_0000_0000_0000, 1, 0, 3'd2, 1, 2'd0);
        drive("R4 ceil",    64'h400C_0000_0000_0000, 1, 0, 3'd3, 1, 2'd3);
        drive("R4 floor",   64'hC00C_0000_0000_0000, 1, 0, 3'd4, 1, 2'd2);
        // R5 forced mode scope: back-to-back
        drive("R5 ceil",    64'h4004_0000_0000_0000, 1, 0, 3'd3, 1, 2'd3);
        drive("R5 cvt after", 64'h4004_0000_0000_0000, 1, 0, 3'd0, 1, 2'd3);
        idle();
        // R6 NaN saturating policy
        drive("R6 qnan",    64'h7FF8_0000_0000_0000, 1, 0, 3'd0, 1, 2'd0);
        drive("R6 snan",    64'h0000_0000_7F80_0001, 0, 1, 3'd2, 1, 2'd0);
        // R7 saturation by sign, R12 flags
        drive("R7 R12 +inf", 64'h0000_0000_7F80_0000, 0, 0, 3'd0, 1, 2'd0);
        drive("R7 -inf",    64'hFFF0_0000_0000_0000, 1, 1, 3'd0, 1, 2'd0);
        drive("R7 +2^33",   64'h4200_0000_0000_0000, 1, 0, 3'd0, 1, 2'd0);
        drive("R7 -2^33",   64'hC200_0000_0000_0000, 1, 0, 3'd0, 1, 2'd0);
        // R8 legacy fixed pattern
        drive("R8 nan",     64'h7FF8_0000_0000_0000, 1, 0, 3'd0, 0, 2'd0);
        drive("R8 -inf",    64'hFFF0_0000_0000_0000, 1, 1, 3'd0, 0, 2'd0);
        drive("R8 -2^33",   64'hC200_0000_0000_0000, 1, 0, 3'd4, 0, 2'd0);
        // R10 zero and subnormals
        drive("R10 zero",   64'h0000_0000_0000_0000, 0, 0, 3'd3, 1, 2'd0);
        drive("R10 sub ceil", 64'h0000_0000_0000_0001, 0, 0, 3'd3, 1, 2'd0);
        drive("R10 sub floor", 64'h0000_0000_8000_0001, 0, 0, 3'd4, 1, 2'd0);
        drive("R10 sub trunc", 64'h0000_0000_0000_0001, 1, 1, 3'd2, 1, 2'd0);
        // R11 boundaries after rounding
        drive("R11 -2^31",  64'hC1E0_0000_0000_0000, 1, 0, 3'd0, 1, 2'd0);
        drive("R11 +2^31",  64'h41E0_0000_0000_0000, 1, 0, 3'd0, 1, 2'd0);
        drive("R11 R9 round up out", 64'h41DF_FFFF_FFE0_0000, 1, 0, 3'd0, 1, 2'd0);
        drive("R11 trunc fits", 64'h41DF_FFFF_FFE0_0000, 1, 0, 3'd2, 1, 2'd0);
        drive("R11 +2^63",  64'h43E0_0000_0000_0000, 1, 1, 3'd0, 1, 2'd0);
        drive("R11 -2^63",  64'hC3E0_0000_0000_0000, 1, 1, 3'd0, 1, 2'd0);
        idle();
        // R3 R4 sweep of small values across ops, modes and widths
        for (int i = -40; i <= 40; i++) begin
            real rv;
            rv = i * 0.75;
            drive("R3 R4 sweep", $realtobits(rv), 1, (i % 3) == 0, 3'((i + 40) % 6),
                  (i % 2) == 0, 2'(((i + 40) / 6) % 4));
        end
        idle();
        idle();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule